// File: doc/BRIEF.md
# Timer Output Compare Pulse Generator

This block pairs a 16-bit up-counter with two compare values and drives one output pin from them. The simple compare modes look only at the first compare value: on a match they set the pin, clear it or toggle it. The dual modes use both values. The pin goes high when the timer reaches the first value and low when it reaches the second. This happens once, or again in every timer period. A one-cycle interrupt pulse marks each match that ends a pulse.

The timer can start in three ways. It can run freely. It can be restarted to zero by a sync pulse taken from one of 31 selectable source lines. In trigger mode it waits, holding its value, until a software strobe or a selected source line sets the trigger status. An inversion control flips the final pin value. A fault input, once enabled, latches a fault flag. While that flag is set, the pin is forced to a chosen level and can optionally be released to high impedance. A single count-enable input stands in for the prescaler and the clock-source selection.

Top module: `oc_pulse_gen`

## Requirements
- R1: When the unit is running and `cnt_en` is high, `tmr` advances by one per clock up to `period` and then wraps to 0. When `cnt_en` is low, `tmr` holds its value.
- R2: With `trig_en` low and `sync_sel` non-zero, a high on `src_in[sync_sel-1]` sets `tmr` to 0 at the next edge. A `sync_sel` of 0 selects no source.
- R3: A match is a counting cycle (`cnt_en` high while running) in which `tmr` equals a compare value. The pin changes at the following edge. Mode 3'b001 sets the pin on a `cmp_a` match, 3'b010 clears it and 3'b011 toggles it. Modes 3'b000, 3'b110 and 3'b111 hold the pin low.
- R4: In modes 3'b100 and 3'b101 the pin rises on a `cmp_a` match and falls on a `cmp_b` match. If both match at once, the fall wins. If `cmp_b` is above `period`, the pin never falls.
- R5: Mode 3'b101 repeats the rise and the fall in every timer period.
- R6: In mode 3'b100, a `cmp_b` match makes `mode` read 3'b000 from the next edge, and the pin stays low after that. A `mode_wr` strobe loads `mode_in` and takes priority over this self-clear.
- R7: With `trig_en` high and `trig_stat` low, the timer holds and no match occurs.
- R8: With `trig_en` high, `trig_stat` is set by `sw_trig` or by the selected source line. It is cleared when the timer wraps while `trig_auto` is high, unless a set arrives in the same cycle. It reads 0 whenever `trig_en` is low.
- R9: When no fault is latched, `out_inv` inverts `oc_out` relative to the internal pin state.
- R10: `flt_en` and `flt_in` both high sets `flt_flag` at the next edge. While the flag is set, `oc_out` equals `flt_state`. A `flt_clr` strobe clears the flag only when `flt_in` is low.
- R11: `oc_oe` is low exactly while `flt_flag` and `flt_tri_en` are both high.
- R12: `irq` is high for the cycle after a `cmp_b` match in the dual modes. In modes 3'b001 to 3'b011 it is high for the cycle after a `cmp_a` match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable for the time base |
| period | input | 16 | Last count before the timer wraps |
| cmp_a | input | 16 | Rising-edge / single compare value |
| cmp_b | input | 16 | Falling-edge compare value |
| mode_wr | input | 1 | Strobe that loads mode_in |
| mode_in | input | 3 | New compare mode |
| trig_en | input | 1 | Trigger mode enable (low means synchronous mode) |
| trig_auto | input | 1 | Clear trigger status when the timer wraps |
| sw_trig | input | 1 | Software trigger strobe |
| sync_sel | input | 5 | Sync/trigger source select, 0 = none |
| src_in | input | 31 | Sync/trigger source lines |
| out_inv | input | 1 | Invert the output |
| flt_en | input | 1 | Fault input enable |
| flt_in | input | 1 | Fault input, active high |
| flt_state | input | 1 | Pin level forced during a fault |
| flt_tri_en | input | 1 | Release the pin while a fault is latched |
| flt_clr | input | 1 | Write-one-to-clear strobe for the fault flag |
| oc_out | output | 1 | Compare output pin value |
| oc_oe | output | 1 | Pin output enable |
| irq | output | 1 | One-cycle match interrupt |
| flt_flag | output | 1 | Latched fault status |
| trig_stat | output | 1 | Trigger status |
| mode | output | 3 | Current compare mode |
| tmr | output | 16 | Timer value |

## Verification
A wrong timer value shows up on `tmr` at the very next clock edge. In a compare mode, `oc_out` also goes wrong at the first match that follows, because every match decision depends on the timer. A lost single-shot self-clear shows on `mode` one cycle after the falling match. A second pulse then appears within the next period. A trigger status that is set or cleared wrongly shows on `tmr` within one cycle, as a timer that counts when it should hold or holds when it should count. The fault latch shows its errors on `flt_flag`, `oc_out` and `oc_oe` one edge after the fault input or the clear strobe changes. The bench runs a behavioural model next to the design and compares every output on every cycle, so any of these errors is caught at the first cycle in which it is visible.

// File: rtl/oc_pulse_gen.sv
module oc_pulse_gen #(
  parameter int W    = 16,
  parameter int SELW = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cnt_en,
  input  logic [W-1:0]           period,
  input  logic [W-1:0]           cmp_a,
  input  logic [W-1:0]           cmp_b,
  input  logic                   mode_wr,
  input  logic [2:0]             mode_in,
  input  logic                   trig_en,
  input  logic                   trig_auto,
  input  logic                   sw_trig,
  input  logic [SELW-1:0]        sync_sel,
  input  logic [(2**SELW)-2:0]   src_in,
  input  logic                   out_inv,
  input  logic                   flt_en,
  input  logic                   flt_in,
  input  logic                   flt_state,
  input  logic                   flt_tri_en,
  input  logic                   flt_clr,
  output logic                   oc_out,
  output logic                   oc_oe,
  output logic                   irq,
  output logic                   flt_flag,
  output logic                   trig_stat,
  output logic [2:0]             mode,
  output logic [W-1:0]           tmr
);
  localparam int NSRC = 2**SELW;

  logic [NSRC-1:0] src_vec;
  logic src_hit, go, wrap, hit_a, hit_b, dual, pin, pin_nx, irq_nx;

  assign src_vec = {src_in, 1'b0};
  assign src_hit = src_vec[sync_sel];
  assign go      = cnt_en & (~trig_en | trig_stat);
  assign wrap    = go & (tmr >= period);
  assign hit_a   = go & (tmr == cmp_a);
  assign hit_b   = go & (tmr == cmp_b);
  assign dual    = mode[2] & ~mode[1];

  always_comb begin
    case (mode)
      3'b001:         pin_nx = pin | hit_a;
      3'b010:         pin_nx = pin & ~hit_a;
      3'b011:         pin_nx = pin ^ hit_a;
      3'b100, 3'b101: pin_nx = hit_b ? 1'b0 : (hit_a ? 1'b1 : pin);
      default:        pin_nx = 1'b0;
    endcase
    if (dual)                          irq_nx = hit_b;
    else if (mode != 3'b000 && !mode[2]) irq_nx = hit_a;
    else                               irq_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr       <= '0;
      trig_stat <= 1'b0;
      mode      <= 3'b000;
      flt_flag  <= 1'b0;
      pin       <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (!trig_en && src_hit) tmr <= '0;
      else if (go)             tmr <= wrap ? '0 : tmr + W'(1);

      if (!trig_en)                trig_stat <= 1'b0;
      else if (sw_trig || src_hit) trig_stat <= 1'b1;
      else if (trig_auto && wrap)  trig_stat <= 1'b0;

      if (mode_wr)                         mode <= mode_in;
      else if (mode == 3'b100 && hit_b)    mode <= 3'b000;

      if (flt_en && flt_in)        flt_flag <= 1'b1;
      else if (flt_clr && !flt_in) flt_flag <= 1'b0;

      pin <= pin_nx;
      irq <= irq_nx;
    end
  end

  assign oc_out = flt_flag ? flt_state : (pin ^ out_inv);
  assign oc_oe  = ~(flt_flag & flt_tri_en);
endmodule

// File: rtl/oc_pulse_gen_chk.sv
module oc_pulse_gen_chk #(
  parameter int W    = 16,
  parameter int SELW = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cnt_en,
  input logic [W-1:0]         period,
  input logic [W-1:0]         cmp_a,
  input logic [W-1:0]         cmp_b,
  input logic                 mode_wr,
  input logic [2:0]           mode_in,
  input logic                 trig_en,
  input logic                 trig_auto,
  input logic                 sw_trig,
  input logic [SELW-1:0]      sync_sel,
  input logic [(2**SELW)-2:0] src_in,
  input logic                 out_inv,
  input logic                 flt_en,
  input logic                 flt_in,
  input logic                 flt_state,
  input logic                 flt_tri_en,
  input logic                 flt_clr,
  input logic                 oc_out,
  input logic                 oc_oe,
  input logic                 irq,
  input logic                 flt_flag,
  input logic                 trig_stat,
  input logic [2:0]           mode,
  input logic [W-1:0]         tmr
);
  logic [(2**SELW)-1:0] sv;
  assign sv = {src_in, 1'b0};

  // R1
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !trig_en && !sv[sync_sel] && tmr < period) |=> tmr == $past(tmr) + W'(1));

  // R2
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_en && sv[sync_sel]) |=> tmr == '0);

  // R7
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_en && !trig_stat) |=> tmr == $past(tmr));

  // R6
  oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(mode) == 3'b100 && !$past(mode_wr)) |-> mode == 3'b000);

  // R10
  flt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && flt_in) |=> flt_flag);

  // R10
  flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_flag && flt_in) |=> flt_flag);
endmodule

bind oc_pulse_gen oc_pulse_gen_chk #(.W(W), .SELW(SELW)) u_chk (.*);

// File: tb/oc_pulse_gen_tb.sv
module oc_pulse_gen_tb;
  logic clk = 0, rst_n = 0, cnt_en = 0;
  logic [15:0] period = 0, cmp_a = 0, cmp_b = 0;
  logic mode_wr = 0; logic [2:0] mode_in = 0;
  logic trig_en = 0, trig_auto = 0, sw_trig = 0;
  logic [4:0] sync_sel = 0; logic [30:0] src_in = 0;
  logic out_inv = 0, flt_en = 0, flt_in = 0, flt_state = 0, flt_tri_en = 0, flt_clr = 0;
  logic oc_out, oc_oe, irq, flt_flag, trig_stat;
  logic [2:0] mode; logic [15:0] tmr;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int m_tmr = 0, m_mode = 0, m_trig = 0, m_pin = 0, m_flt = 0, m_irq = 0;
  bit last_src = 0;

  always #4 clk = ~clk;

  oc_pulse_gen u_dut (.*);

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit sel_src();
    return (sync_sel != 0) && src_in[sync_sel - 1];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_tmr = 0; m_mode = 0; m_trig = 0; m_pin = 0; m_flt = 0; m_irq = 0; last_src = 0;
    end else begin
      bit s, run, a, b, wr;
      int np, ni;
      s = sel_src();
      last_src = s;
      run = cnt_en && (!trig_en || m_trig != 0);
      a = run && (m_tmr == int'(cmp_a));
      b = run && (m_tmr == int'(cmp_b));
      wr = run && (m_tmr >= int'(period));
      np = 0; ni = 0;
      if (m_mode == 1) begin np = a ? 1 : m_pin; ni = a; end
      else if (m_mode == 2) begin np = a ? 0 : m_pin; ni = a; end
      else if (m_mode == 3) begin np = a ? 1 - m_pin : m_pin; ni = a; end
      else if (m_mode == 4 || m_mode == 5) begin
        np = b ? 0 : (a ? 1 : m_pin); ni = b;
      end
      m_pin = np; m_irq = ni;
      if (!trig_en && s) m_tmr = 0;
      else if (run) m_tmr = wr ? 0 : m_tmr + 1;
      if (!trig_en) m_trig = 0;
      else if (sw_trig || s) m_trig = 1;
      else if (trig_auto && wr) m_trig = 0;
      if (mode_wr) m_mode = int'(mode_in);
      else if (m_mode == 4 && b) m_mode = 0;
      if (flt_en && flt_in) m_flt = 1;
      else if (flt_clr && !flt_in) m_flt = 0;
    end
    #2;
    begin
      int exp_out;
      string oreq, treq;
      exp_out = m_flt ? int'(flt_state) : (m_pin ^ int'(out_inv));
      if (m_flt) oreq = "R10";
      else if (out_inv) oreq = "R9";
      else if (m_mode == 5) oreq = "R5";
      else if (m_mode == 4) oreq = "R4";
      else oreq = "R3";
      treq = trig_en ? "R7" : (last_src ? "R2" : "R1");
      chk(treq, int'(tmr), m_tmr, "tmr");
      chk(oreq, int'(oc_out), exp_out, "oc_out");
      chk("R11", int'(oc_oe), (m_flt && flt_tri_en) ? 0 : 1, "oc_oe");
      chk("R12", int'(irq), m_irq, "irq");
      chk("R6", int'(mode), m_mode, "mode");
      chk("R8", int'(trig_stat), m_trig, "trig_stat");
      chk("R10", int'(flt_flag), m_flt, "flt_flag");
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(int m);
    @(negedge clk); mode_in = 3'(m); mode_wr = 1;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_trig = 1;
    @(negedge clk); sw_trig = 0;
  endtask

  initial begin
    wait_n(3);
    rst_n = 1;
    // R1: free-running count and wrap
    period = 9; cmp_a = 4; cmp_b = 7; cnt_en = 1;
    wait_n(25);
    // R3: set, clear, toggle on match
    for (int m = 1; m <= 3; m++) begin set_mode(m); wait_n(40); end
    set_mode(6); wait_n(15);
    // R4 / R5 / R12: continuous dual compare, then fall beyond period
    period = 11; cmp_a = 2; cmp_b = 6; set_mode(5); wait_n(50);
    cmp_b = 14; wait_n(30);
    cmp_a = 5; cmp_b = 5; wait_n(30);
    // R6: single shot, self-clear
    cmp_a = 3; cmp_b = 8; set_mode(4); wait_n(40);
    // R1: count enable gaps
    set_mode(5);
    for (int i = 0; i < 40; i++) begin @(negedge clk); cnt_en = (i % 3) != 0; end
    cnt_en = 1;
    // R2: sync restarts
    sync_sel = 3;
    for (int i = 0; i < 4; i++) begin
      wait_n(7); src_in[2] = 1; @(negedge clk); src_in[2] = 0;
    end
    wait_n(10);
    // R7 / R8: trigger mode, software then hardware trigger, auto clear
    trig_en = 1; trig_auto = 1; wait_n(15);
    pulse_sw(); wait_n(30);
    src_in[2] = 1; @(negedge clk); src_in[2] = 0; wait_n(30);
    trig_auto = 0; pulse_sw(); wait_n(30);
    trig_en = 0; sync_sel = 0; wait_n(10);
    // R9: inversion
    out_inv = 1; wait_n(30); out_inv = 0;
    // R10 / R11: fault latch, clear blocked while active, tristate
    flt_state = 1; flt_tri_en = 1; flt_en = 1; flt_in = 1; wait_n(5);
    flt_clr = 1; @(negedge clk); flt_clr = 0; wait_n(3);
    flt_in = 0; wait_n(5);
    flt_clr = 1; @(negedge clk); flt_clr = 0; wait_n(10);
    flt_en = 0; flt_in = 1; wait_n(5); flt_in = 0;
    // mixed random traffic
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      cnt_en = $urandom_range(0, 7) != 0;
      mode_wr = $urandom_range(0, 60) == 0;
      mode_in = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 200) == 0) begin
        period = 16'($urandom_range(0, 15));
        cmp_a = 16'($urandom_range(0, 17));
        cmp_b = 16'($urandom_range(0, 17));
        trig_en = $urandom_range(0, 2) == 0;
        trig_auto = $urandom_range(0, 1) != 0;
        sync_sel = 5'($urandom_range(0, 3));
        out_inv = $urandom_range(0, 3) == 0;
        flt_en = $urandom_range(0, 3) == 0;
        flt_state = $urandom_range(0, 1) != 0;
        flt_tri_en = $urandom_range(0, 1) != 0;
      end
      sw_trig = $urandom_range(0, 40) == 0;
      src_in = 31'($urandom_range(0, 30) == 0 ? 7 : 0);
      flt_in = $urandom_range(0, 50) == 0;
      flt_clr = $urandom_range(0, 20) == 0;
    end
    wait_n(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule